// File: doc/BRIEF.md
# Miss-Tolerant Register Cache Operand Read Pipeline

This block is the operand-read back end of an out-of-order core. A small, fully associative register cache sits in front of a main register file that has only a few read ports. Every issued source operand takes the same path, whether it hits or misses. In the first stage the operand is compared against the cache tags, and only the match result and the matching entry are latched. In the second stage the cached data array supplies hitting operands, while missing operands are read from the main register file. Every operand therefore reaches execute a fixed two cycles after issue.

A single miss never disturbs the flow. The pipeline holds only when the operands waiting in the tag-latch stage need more main-file reads than there are read ports. In that case the misses are served in operand order, up to the port count per cycle, and the group is released in the cycle that its last miss is read.

Results arrive on one write port. Each result is written to the main file and into the cache at the same time, taking a free entry or evicting the least recently used one. If an eviction removes an entry that a latched operand matched, that operand is redirected to the main file.

Top module: `rcache_read_pipe`

## Requirements
- R1: With no more misses than read ports, operands issued at one clock edge appear on `opData`, with `opValid` set, after the next clock edge. This holds for hits and misses alike, and a new group may be issued at every edge.
- R2: Each delivered operand equals the value most recently written to its physical register, or zero if that register was never written.
- R3: `opHit[i]` is 1 when operand i was supplied by the register cache and 0 when the main register file supplied it.
- R4: `stall` is asserted only while the operands of valid lanes in the tag-latch stage have more pending misses than `RD_PORTS`. A group with m misses (m > 0) stalls for ceil(m / RD_PORTS) - 1 cycles. Operands of invalid lanes never count as misses.
- R5: While `stall` is high, the issue inputs are ignored, `opValid` stays 0 in the following cycle, and the held group is delivered complete and correct once the stall ends.
- R6: An operand issued in the same cycle that its register is written receives the newly written value.
- R7: A write to a register that is not cached fills the lowest-index free entry. If no entry is free, it evicts the entry with the highest recency age, taking the lowest index on a tie. Ages saturate at 2^AGE_W - 1. Writes and cache-served reads reset an entry's age to 0.
- R8: When a write evicts an entry that a newly issued or held operand matched in the tag stage, that operand reports `opHit` = 0 and receives its value from the main register file.
- R9: `stallCycles` counts the cycles in which `stall` is high, saturating at its maximum value.
- R10: After reset, `stall`, `opValid` and `stallCycles` are 0, the cache holds no entries, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | LANES | One valid bit per issue lane |
| issueSrc | input | 2*LANES x log2(PREGS) | Source physical register numbers; operand 2l and 2l+1 belong to lane l |
| wrEn | input | 1 | Result write strobe |
| wrPreg | input | log2(PREGS) | Physical register being written |
| wrData | input | DATA_W | Result value |
| stall | output | 1 | Issue must be held this cycle |
| opValid | output | LANES | Per-lane valid bit of operands going to execute |
| opData | output | 2*LANES x DATA_W | Operand values going to execute |
| opHit | output | 2*LANES | Operand was served by the register cache |
| stallCycles | output | CNT_W | Saturating count of stalled cycles |

## Verification
The hardest case to reach is R8: a write must pick as its victim exactly the entry that an operand matched in that same cycle. From the ports, this means steering the recency ages. The stimulus first idles long enough for every age to saturate. It then reads every cached register except one, so that register's entry is the only oldest one. Finally it issues that register in the same cycle as a write to an uncached register. The all-miss sweep over the four operands, combined with the write-order fill of the cache, covers every hit/miss mix and stall length.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic advance;  // tag-latch stage moves on; output stage loads
    logic serve;    // granted main-file reads are parked in the side buffer
  } rcpStrobes_t;

endpackage

// File: rtl/rcp_ctrl.sv
module rcp_ctrl
  import rcp_pkg::*;
#(
  parameter int OPS   = 4,
  parameter int RP    = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPS-1:0]   rsMiss,
  output rcpStrobes_t      strobes,
  output logic [OPS-1:0]   grant,
  output logic             stall,
  output logic [CNT_W-1:0] stallCycles
);

  logic [OPS-1:0] doneMask;
  logic [OPS-1:0] pending;
  logic           complete;

  assign pending = rsMiss & ~doneMask;

  // Grant main-file read ports to pending misses in operand order.
  always_comb begin
    int taken;
    taken = 0;
    grant = '0;
    for (int i = 0; i < OPS; i++) begin
      if (pending[i] && taken < RP) begin
        grant[i] = 1'b1;
        taken++;
      end
    end
  end

  assign complete        = $countones(pending) <= RP;
  assign stall           = !complete;
  assign strobes.advance = complete;
  assign strobes.serve   = !complete && (grant != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneMask    <= '0;
      stallCycles <= '0;
    end else begin
      if (complete) doneMask <= '0;
      else          doneMask <= doneMask | grant;
      if (stall && stallCycles != '1) stallCycles <= stallCycles + 1'b1;
    end
  end

endmodule

// File: rtl/rcp_dpath.sv
module rcp_dpath
  import rcp_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int PREGS   = 32,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4,
  localparam int OPS    = 2 * LANES,
  localparam int PREG_W = $clog2(PREGS),
  localparam int WAY_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               issueValid,
  input  logic [OPS-1:0][PREG_W-1:0]     issueSrc,
  input  logic                           wrEn,
  input  logic [PREG_W-1:0]              wrPreg,
  input  logic [DATA_W-1:0]              wrData,
  input  rcpStrobes_t                    strobes,
  input  logic [OPS-1:0]                 grant,
  output logic [OPS-1:0]                 rsMiss,
  output logic [LANES-1:0]               opValid,
  output logic [OPS-1:0][DATA_W-1:0]     opData,
  output logic [OPS-1:0]                 opHit
);

  // Register cache arrays and main register file
  logic [PREG_W-1:0] tagArr  [ENTRIES];
  logic              entValid[ENTRIES];
  logic [DATA_W-1:0] dataArr [ENTRIES];
  logic [AGE_W-1:0]  entAge  [ENTRIES];
  logic [DATA_W-1:0] mainRf  [PREGS];

  // Tag-latch stage: match result only, no data
  logic [OPS-1:0]              rsOpValid;
  logic [OPS-1:0][PREG_W-1:0]  rsPreg;
  logic [OPS-1:0]              rsHit;
  logic [OPS-1:0][WAY_W-1:0]   rsWay;
  logic [OPS-1:0][DATA_W-1:0]  sideBuf;

  logic [OPS-1:0]              lkHit;
  logic [OPS-1:0][WAY_W-1:0]   lkWay;
  logic                        wrHit;
  logic [WAY_W-1:0]            wrWay;
  logic [WAY_W-1:0]            victim;
  logic [WAY_W-1:0]            allocWay;
  logic                        evict;
  logic [ENTRIES-1:0]          touch;
  logic [OPS-1:0][DATA_W-1:0]  readVal;

  // Fully associative lookups for issued operands and the write port
  always_comb begin
    for (int i = 0; i < OPS; i++) begin
      lkHit[i] = 1'b0;
      lkWay[i] = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (entValid[e] && tagArr[e] == issueSrc[i]) begin
          lkHit[i] = 1'b1;
          lkWay[i] = WAY_W'(e);
        end
      end
    end
    wrHit = 1'b0;
    wrWay = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (entValid[e] && tagArr[e] == wrPreg) begin
        wrHit = 1'b1;
        wrWay = WAY_W'(e);
      end
    end
  end

  // Victim: lowest free entry, else oldest age with lowest index on ties
  always_comb begin
    logic found;
    logic [AGE_W:0] bestAge;
    found   = 1'b0;
    victim  = '0;
    bestAge = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found && !entValid[e]) begin
        victim = WAY_W'(e);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if ({1'b1, entAge[e]} > bestAge) begin
          bestAge = {1'b1, entAge[e]};
          victim  = WAY_W'(e);
        end
      end
    end
  end

  assign allocWay = wrHit ? wrWay : victim;
  assign evict    = wrEn && !wrHit && entValid[victim];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      touch[e] = wrEn && (allocWay == WAY_W'(e));
      for (int i = 0; i < OPS; i++) begin
        if (strobes.advance && rsOpValid[i] && rsHit[i] && rsWay[i] == WAY_W'(e))
          touch[e] = 1'b1;
      end
    end
  end

  assign rsMiss = rsOpValid & ~rsHit;

  // Final read stage: data array for hits, main file or parked value for misses
  always_comb begin
    for (int i = 0; i < OPS; i++) begin
      if (!rsOpValid[i])  readVal[i] = '0;
      else if (rsHit[i])  readVal[i] = dataArr[rsWay[i]];
      else if (grant[i])  readVal[i] = mainRf[rsPreg[i]];
      else                readVal[i] = sideBuf[i];
    end
  end

  // Storage updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tagArr[e]   <= '0;
        entValid[e] <= 1'b0;
        dataArr[e]  <= '0;
        entAge[e]   <= '0;
      end
      for (int r = 0; r < PREGS; r++) mainRf[r] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (touch[e])           entAge[e] <= '0;
        else if (entAge[e] != '1) entAge[e] <= entAge[e] + 1'b1;
      end
      if (wrEn) begin
        mainRf[wrPreg]     <= wrData;
        tagArr[allocWay]   <= wrPreg;
        entValid[allocWay] <= 1'b1;
        dataArr[allocWay]  <= wrData;
      end
    end
  end

  // Pipeline registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsOpValid <= '0;
      rsPreg    <= '0;
      rsHit     <= '0;
      rsWay     <= '0;
      sideBuf   <= '0;
      opValid   <= '0;
      opData    <= '0;
      opHit     <= '0;
    end else if (strobes.advance) begin
      for (int i = 0; i < OPS; i++) begin
        rsOpValid[i] <= issueValid[i/2];
        rsPreg[i]    <= issueSrc[i];
        rsHit[i]     <= lkHit[i] && !(evict && lkWay[i] == victim);
        rsWay[i]     <= lkWay[i];
        opData[i]    <= readVal[i];
        opHit[i]     <= rsOpValid[i] && rsHit[i];
      end
      for (int l = 0; l < LANES; l++) opValid[l] <= rsOpValid[2*l];
    end else begin
      opValid <= '0;
      for (int i = 0; i < OPS; i++) begin
        if (evict && rsWay[i] == victim) rsHit[i] <= 1'b0;
        if (strobes.serve && grant[i])   sideBuf[i] <= mainRf[rsPreg[i]];
      end
    end
  end

endmodule

// File: rtl/rcache_read_pipe.sv
module rcache_read_pipe
  import rcp_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int PREGS    = 32,
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int AGE_W    = 4,
  parameter int CNT_W    = 16,
  localparam int OPS     = 2 * LANES,
  localparam int PREG_W  = $clog2(PREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           issueValid,
  input  logic [OPS-1:0][PREG_W-1:0] issueSrc,
  input  logic                       wrEn,
  input  logic [PREG_W-1:0]          wrPreg,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       stall,
  output logic [LANES-1:0]           opValid,
  output logic [OPS-1:0][DATA_W-1:0] opData,
  output logic [OPS-1:0]             opHit,
  output logic [CNT_W-1:0]           stallCycles
);

  rcpStrobes_t    strobes;
  logic [OPS-1:0] grantVec;
  logic [OPS-1:0] rsMiss;

  rcp_ctrl #(.OPS(OPS), .RP(RD_PORTS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rsMiss(rsMiss), .strobes(strobes),
    .grant(grantVec), .stall(stall), .stallCycles(stallCycles)
  );

  rcp_dpath #(.LANES(LANES), .PREGS(PREGS), .DATA_W(DATA_W),
              .ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueSrc(issueSrc),
    .wrEn(wrEn), .wrPreg(wrPreg), .wrData(wrData), .strobes(strobes),
    .grant(grantVec), .rsMiss(rsMiss), .opValid(opValid), .opData(opData),
    .opHit(opHit)
  );

endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
  parameter int LANES = 2,
  parameter int OPS   = 4,
  parameter int RP    = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic [OPS-1:0]   grant,
  input logic [OPS-1:0]   rsMiss,
  input logic [LANES-1:0] opValid,
  input logic [CNT_W-1:0] stallCycles
);

  // R4: never more main-file reads than ports
  p_port_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= RP);

  // R4: a stall needs a port shortfall
  p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $countones(rsMiss) > RP);

  // R4: enough ports means no stall
  p_no_shortfall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rsMiss) <= RP) |-> !stall);

  // R5: nothing reaches execute after a stalled cycle
  p_quiet_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> opValid == '0);

  // R9: counter steps on stall, holds otherwise
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stallCycles != '1) |=> stallCycles == $past(stallCycles) + CNT_W'(1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(stallCycles));

endmodule

bind rcache_read_pipe rcp_checker #(.LANES(LANES), .OPS(OPS), .RP(RD_PORTS), .CNT_W(CNT_W)) u_rcpChk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .grant(grantVec), .rsMiss(rsMiss),
  .opValid(opValid), .stallCycles(stallCycles)
);

// File: tb/tb_rcache_read_pipe.sv
`timescale 1ns/1ps
module tb_rcache_read_pipe;
  localparam int LANES = 2, OPS = 4, PREGS = 32, PREG_W = 5, DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [LANES-1:0] issueValid;
  logic [OPS-1:0][PREG_W-1:0] issueSrc;
  logic wrEn;
  logic [PREG_W-1:0] wrPreg;
  logic [DATA_W-1:0] wrData;
  logic stall;
  logic [LANES-1:0] opValid;
  logic [OPS-1:0][DATA_W-1:0] opData;
  logic [OPS-1:0] opHit;
  logic [15:0] stallCycles;

  int checks = 0, errors = 0, expStalls = 0;
  bit finished = 0;
  logic [DATA_W-1:0] refRf [PREGS];

  always #5 clk = ~clk;

  rcache_read_pipe dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueSrc(issueSrc),
    .wrEn(wrEn), .wrPreg(wrPreg), .wrData(wrData), .stall(stall),
    .opValid(opValid), .opData(opData), .opHit(opHit), .stallCycles(stallCycles)
  );

  function automatic logic [31:0] val(input int p, input int gen);
    return 32'h1000_0000 + 32'(p) * 32'h0000_0101 + 32'(gen) * 32'h0100_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wrEn = 1'b0;
      issueValid = '0;
    end
  endtask

  task automatic writeReg(input int p, input logic [31:0] v);
    @(negedge clk);
    issueValid = '0;
    wrEn = 1'b1; wrPreg = PREG_W'(p); wrData = v;
    refRf[p] = v;
  endtask

  // Issue one group; optionally write in the same cycle; check after latency
  task automatic runGroup(input int p0, input int p1, input int p2, input int p3,
                          input logic [1:0] lv, input logic [3:0] eh, input int es,
                          input bit doWr, input int wp, input logic [31:0] wv,
                          input string req);
    int pp[4];
    pp[0] = p0; pp[1] = p1; pp[2] = p2; pp[3] = p3;
    @(negedge clk);
    issueValid = lv;
    for (int i = 0; i < OPS; i++) issueSrc[i] = PREG_W'(pp[i]);
    wrEn = doWr;
    if (doWr) begin
      wrPreg = PREG_W'(wp); wrData = wv; refRf[wp] = wv;
    end
    @(negedge clk);
    issueValid = '0; wrEn = 1'b0;
    chk(stall == (es > 0), "R4", "stall", 32'(stall), 32'(es > 0));
    repeat (es + 1) @(negedge clk);
    chk(opValid == lv, req, "opValid", 32'(opValid), 32'(lv));
    for (int i = 0; i < OPS; i++) begin
      if (lv[i/2]) begin
        chk(opHit[i] == eh[i], (req == "R2") ? "R3" : req, "opHit", 32'(opHit[i]), 32'(eh[i]));
        chk(opData[i] == refRf[pp[i]], (req == "R2") ? "R2" : req, "opData", opData[i], refRf[pp[i]]);
      end
    end
    expStalls += es;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sp[8][4];
    logic [3:0] sh[8];
    for (int r = 0; r < PREGS; r++) refRf[r] = '0;
    rst_n = 1'b0; issueValid = '0; issueSrc = '0;
    wrEn = 1'b0; wrPreg = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(stall == 1'b0, "R10", "stall", 32'(stall), 0);
    chk(opValid == '0, "R10", "opValid", 32'(opValid), 0);
    chk(stallCycles == '0, "R10", "stallCycles", 32'(stallCycles), 0);
    // R10/R4: empty cache, zero registers, invalid lane adds no misses
    runGroup(30, 31, 28, 29, 2'b01, 4'b0000, 0, 0, 0, 0, "R10");

    // Fill: 8..31 first, then 0..7, leaving 0..7 cached in entries 0..7 (R7)
    for (int p = 8; p < 32; p++) writeReg(p, val(p, 0));
    for (int p = 0; p < 8; p++) writeReg(p, val(p, 0));
    idle(2);

    // R4/R2/R3: sweep all hit/miss masks over the four operands
    for (int m = 0; m < 16; m++) begin
      int mc;
      mc = $countones(4'(m));
      runGroup(m[0] ? 16 : 0, m[1] ? 17 : 1, m[2] ? 18 : 2, m[3] ? 19 : 3,
               2'b11, ~4'(m), (mc > 2) ? 1 : 0, 0, 0, 0, "R2");
    end

    // R1: back-to-back groups, at most two misses each
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk(opValid == 2'b11, "R1", "opValid", 32'(opValid), 3);
        for (int i = 0; i < OPS; i++) begin
          chk(opHit[i] == sh[k-2][i], "R1", "opHit", 32'(opHit[i]), 32'(sh[k-2][i]));
          chk(opData[i] == refRf[sp[k-2][i]], "R1", "opData", opData[i], refRf[sp[k-2][i]]);
        end
      end
      chk(stall == 1'b0, "R1", "stall", 32'(stall), 0);
      if (k < 8) begin
        for (int i = 0; i < OPS; i++) begin
          sh[k][i] = ((k + i) % 3) != 0;
          sp[k][i] = sh[k][i] ? (k + i) % 8 : 16 + (k + i) % 16;
          issueSrc[i] = PREG_W'(sp[k][i]);
        end
        issueValid = 2'b11;
      end else issueValid = '0;
    end

    // R5: issue inputs ignored during a stall
    @(negedge clk);
    issueValid = 2'b11;
    for (int i = 0; i < OPS; i++) issueSrc[i] = PREG_W'(16 + i);
    @(negedge clk);
    chk(stall == 1'b1, "R5", "stall", 32'(stall), 1);
    for (int i = 0; i < OPS; i++) issueSrc[i] = PREG_W'(i);
    @(negedge clk);
    chk(opValid == '0, "R5", "opValid during stall", 32'(opValid), 0);
    issueValid = '0;
    @(negedge clk);
    chk(opValid == 2'b11, "R5", "opValid", 32'(opValid), 3);
    for (int i = 0; i < OPS; i++) begin
      chk(opHit[i] == 1'b0, "R5", "opHit", 32'(opHit[i]), 0);
      chk(opData[i] == refRf[16 + i], "R5", "opData", opData[i], refRf[16 + i]);
    end
    @(negedge clk);
    chk(opValid == '0, "R5", "ignored group", 32'(opValid), 0);
    expStalls += 1;
    chk(stallCycles == 16'(expStalls), "R9", "stallCycles", 32'(stallCycles), 32'(expStalls));

    // R7: ages saturate, touch entry 0, next allocation evicts entry 1 (reg 1)
    idle(20);
    runGroup(0, 0, 0, 0, 2'b01, 4'b1111, 0, 0, 0, 0, "R7");
    writeReg(24, val(24, 1));
    runGroup(1, 0, 24, 2, 2'b11, 4'b1110, 0, 0, 0, 0, "R7");

    // R8: make entry 2 the only oldest, then evict it while its match is latched
    idle(20);
    runGroup(0, 24, 3, 4, 2'b11, 4'b1111, 0, 0, 0, 0, "R7");
    runGroup(5, 6, 7, 0, 2'b11, 4'b1111, 0, 0, 0, 0, "R7");
    runGroup(2, 0, 3, 4, 2'b11, 4'b1110, 0, 1, 25, val(25, 1), "R8");
    runGroup(2, 25, 0, 3, 2'b11, 4'b1110, 0, 0, 0, 0, "R8");

    // R6: operand issued alongside the write of its register
    runGroup(20, 20, 0, 0, 2'b01, 4'b0000, 0, 1, 20, val(20, 2), "R6");

    idle(2);
    chk(stallCycles == 16'(expStalls), "R9", "stallCycles", 32'(stallCycles), 32'(expStalls));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule